// File: doc/BRIEF.md
# Register-Controlled Byte SPI Master

This block is a serial peripheral master that a processor drives through a small register window. Software chooses a select line and asserts it, then writes one byte to the transmit register. The controller shifts that byte out on MOSI while it shifts a byte in from MISO. When the received byte is in the receive register, a completion flag in the cause register goes high. The flag can raise an interrupt if its mask bit is set. The select line stays asserted across any number of bytes until software releases it.

The serial timing can be set through configuration fields. These cover the SCK rate (a prescaler with a floor value), SCK idle level and capture edge (all four SPI modes), and the bit order of each direction on its own. A timing field can move the MISO capture one core clock later. This helps with slow return paths at high SCK rates.

The shift engine is a five-state machine. ST_IDLE goes to ST_LEAD when a transmit write is accepted. ST_LEAD goes to ST_TRAIL when its half period ends, and this is the leading SCK edge. ST_TRAIL goes back to ST_LEAD at the trailing edge when bits remain, or to ST_DRAIN after the last bit. ST_DRAIN always goes to ST_LAND, which leaves room for a delayed capture. ST_LAND always returns to ST_IDLE, and on that edge it delivers the byte and sets the flag.

Top module: `spi_regmaster`

## Requirements
- R1: After reset all select outputs are high, SCK is low, irq is low, and the cause, mask, control and receive registers read 0. The configuration register reads 0x010 and the timing register reads 1.
- R2: The register port is always ready (reg_ready=1). A write takes effect on the clock edge where reg_valid and reg_we are high. Read data follows reg_addr combinationally. The word addresses are: 0 control, 1 configuration, 2 transmit, 3 receive, 4 cause, 5 mask, 6 timing.
- R3: A write to the transmit register while idle starts one 8-bit full-duplex exchange using only wdata[7:0]. Control bit 1 (busy) reads 1 from then until the exchange completes.
- R4: SCK rests at the configuration bit 8 level (clock polarity) while idle. With configuration bit 9 (phase) at 0, both sides capture on the leading edge and change data on the trailing edge. With phase at 1 the roles of the two edges are swapped.
- R5: Configuration bit 11 set sends the transmit byte LSB first, otherwise MSB first. Configuration bit 10 set stores the first received bit as receive bit 0, otherwise as bit 7. The two bits act independently.
- R6: Configuration bits [7:0] hold the prescaler P, and each SCK half period lasts P-0x10+1 core clocks. A written value below 0x10 is stored as 0x10, and any value from 0x10 to 0xFF is kept as written.
- R7: At the end of an exchange, cause bit 0 (done) sets on the same edge that busy falls, and the receive register's low 8 bits hold the received byte. Writing 0 to cause bit 0 clears it, writing 1 leaves it unchanged, and it otherwise holds.
- R8: irq is high exactly when cause bit 0 and mask bit 0 are both 1.
- R9: Control bit 0 (select active) drives spi_cs_n[n] low, where n is control bits [5:4]. At most one select is low at any time. The line stays low across consecutive bytes until bit 0 is cleared.
- R10: A write to the transmit register while busy is ignored. The byte in flight is not altered and no extra exchange follows.
- R11: When timing bits [1:0] equal 2, MISO is captured one core clock after each capture edge. Any other value (reset value 1) captures on the edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low select lines |

## Verification
Some properties are checked on every cycle. At most one select is low, and an idle SCK sits at the polarity level. The prescaler never drops below its floor. The done flag is set whenever busy falls and holds until a zero is written to it. The interrupt never fires without the flag. Other behaviours only show up in the bench's scenarios, where a model of the remote device checks the serial waveform. These are the bit content exchanged in every combination of mode, bit order, prescaler and capture timing. They also include the measured half period, the dropped write during busy, and the case where only the delayed capture recovers data from a device that answers one clock late.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int REG_AW      = 3;
    localparam int PRESC_W     = 8;
    localparam int PRESC_FLOOR = 16;

    localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] A_CFG    = 3'd1;
    localparam logic [REG_AW-1:0] A_TXD    = 3'd2;
    localparam logic [REG_AW-1:0] A_RXD    = 3'd3;
    localparam logic [REG_AW-1:0] A_CAUSE  = 3'd4;
    localparam logic [REG_AW-1:0] A_MASK   = 3'd5;
    localparam logic [REG_AW-1:0] A_TIMING = 3'd6;

    localparam logic [1:0] SAMPLE_LATE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_DRAIN,
        ST_LAND
    } xfer_state_e;

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [REG_AW-1:0]         addr,
    input  logic [31:0]               wdata,
    input  logic                      busy,
    input  logic                      land,
    input  logic [BYTE_W-1:0]         rx_byte,
    output logic [31:0]               rdata,
    output logic                      start,
    output logic [BYTE_W-1:0]         tx_byte,
    output logic [PRESC_W-1:0]        presc,
    output logic                      cpol,
    output logic                      cpha,
    output logic                      rx_lsb,
    output logic                      tx_lsb,
    output logic                      late_sample,
    output logic                      cs_act,
    output logic [$clog2(NUM_CS)-1:0] cs_sel,
    output logic                      done_flag,
    output logic                      mask_bit
);
    localparam int CS_W = $clog2(NUM_CS);
    localparam logic [PRESC_W-1:0] FLOOR = PRESC_W'(PRESC_FLOOR);

    logic [1:0]        xlen;
    logic [1:0]        tsel;
    logic [BYTE_W-1:0] rxd;

    assign start       = wr && (addr == A_TXD) && !busy;
    assign tx_byte     = wdata[BYTE_W-1:0];
    assign late_sample = (tsel == SAMPLE_LATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_act    <= 1'b0;
            cs_sel    <= '0;
            presc     <= FLOOR;
            cpol      <= 1'b0;
            cpha      <= 1'b0;
            rx_lsb    <= 1'b0;
            tx_lsb    <= 1'b0;
            xlen      <= 2'd0;
            tsel      <= 2'd1;
            mask_bit  <= 1'b0;
            done_flag <= 1'b0;
            rxd       <= '0;
        end else begin
            if (wr) begin
                unique case (addr)
                    A_CTRL: begin
                        cs_act <= wdata[0];
                        cs_sel <= wdata[4 +: CS_W];
                    end
                    A_CFG: begin
                        presc  <= (wdata[PRESC_W-1:0] < FLOOR) ? FLOOR : wdata[PRESC_W-1:0];
                        cpol   <= wdata[8];
                        cpha   <= wdata[9];
                        rx_lsb <= wdata[10];
                        tx_lsb <= wdata[11];
                        xlen   <= wdata[13:12];
                    end
                    A_CAUSE: if (!wdata[0]) done_flag <= 1'b0;
                    A_MASK:   mask_bit <= wdata[0];
                    A_TIMING: tsel     <= wdata[1:0];
                    default: ;
                endcase
            end
            if (land) begin
                done_flag <= 1'b1;
                rxd       <= rx_byte;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:   rdata = 32'(cs_act) | (32'(busy) << 1) | (32'(cs_sel) << 4);
            A_CFG:    rdata = 32'(presc) | (32'(cpol) << 8) | (32'(cpha) << 9)
                            | (32'(rx_lsb) << 10) | (32'(tx_lsb) << 11) | (32'(xlen) << 12);
            A_RXD:    rdata = 32'(rxd);
            A_CAUSE:  rdata = 32'(done_flag);
            A_MASK:   rdata = 32'(mask_bit);
            A_TIMING: rdata = 32'(tsel);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
    import spi_rm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BYTE_W-1:0]  tx_byte,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               tx_lsb,
    input  logic               rx_lsb,
    input  logic               late_sample,
    input  logic [PRESC_W-1:0] presc,
    input  logic               miso,
    output logic               busy,
    output logic               land,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               sck,
    output logic               mosi
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [PRESC_W-1:0] FLOOR    = PRESC_W'(PRESC_FLOOR);

    xfer_state_e state, nxt;

    logic [PRESC_W-1:0] hcnt, half_len;
    logic [BIT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  txq, rxq, tx_rev, rx_rev;
    logic               half_end, last_bit, samp_now, samp_d, take;
    logic               sck_q, mosi_q;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
        assign tx_rev[i] = tx_byte[BYTE_W-1-i];
        assign rx_rev[i] = rxq[BYTE_W-1-i];
    end

    assign half_len = presc - FLOOR;
    assign half_end = (hcnt == half_len);
    assign last_bit = (bitcnt == LAST_BIT);
    assign samp_now = half_end && (((state == ST_LEAD) && !cpha) || ((state == ST_TRAIL) && cpha));
    assign take     = late_sample ? samp_d : samp_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (half_end) nxt = ST_TRAIL;
            ST_TRAIL: if (half_end) nxt = last_bit ? ST_DRAIN : ST_LEAD;
            ST_DRAIN: nxt = ST_LAND;
            ST_LAND:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt   <= '0;
            bitcnt <= '0;
            txq    <= '0;
            rxq    <= '0;
            samp_d <= 1'b0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            samp_d <= samp_now;
            if (take) rxq <= {rxq[BYTE_W-2:0], miso};
            unique case (state)
                ST_IDLE: begin
                    sck_q  <= cpol;
                    hcnt   <= '0;
                    bitcnt <= '0;
                    if (start) begin
                        txq <= tx_lsb ? tx_rev : tx_byte;
                        if (!cpha) mosi_q <= tx_lsb ? tx_byte[0] : tx_byte[BYTE_W-1];
                    end
                end
                ST_LEAD: begin
                    if (half_end) begin
                        hcnt  <= '0;
                        sck_q <= ~cpol;
                        if (cpha) mosi_q <= txq[BYTE_W-1];
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (half_end) begin
                        hcnt   <= '0;
                        sck_q  <= cpol;
                        bitcnt <= bitcnt + 1'b1;
                        txq    <= {txq[BYTE_W-2:0], 1'b0};
                        if (!cpha && !last_bit) mosi_q <= txq[BYTE_W-2];
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_DRAIN: ;
                ST_LAND:  ;
                default:  ;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign land    = (state == ST_LAND);
    assign rx_byte = rx_lsb ? rx_rev : rxq;
    assign sck     = sck_q;
    assign mosi    = mosi_q;

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_valid,
    output logic                reg_ready,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq,
    output logic                spi_sck,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [NUM_CS-1:0]   spi_cs_n
);
    localparam int CS_W = $clog2(NUM_CS);

    logic               start, busy, land;
    logic [BYTE_W-1:0]  tx_byte, rx_byte;
    logic [PRESC_W-1:0] cfg_presc;
    logic               cfg_cpol, cfg_cpha, cfg_rx_lsb, cfg_tx_lsb, late_sample;
    logic               cs_act, done_flag, mask_bit;
    logic [CS_W-1:0]    cs_sel;

    assign reg_ready = 1'b1;

    spi_rm_regs #(.NUM_CS(NUM_CS), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_valid && reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .land(land), .rx_byte(rx_byte), .rdata(reg_rdata),
        .start(start), .tx_byte(tx_byte), .presc(cfg_presc),
        .cpol(cfg_cpol), .cpha(cfg_cpha), .rx_lsb(cfg_rx_lsb), .tx_lsb(cfg_tx_lsb),
        .late_sample(late_sample), .cs_act(cs_act), .cs_sel(cs_sel),
        .done_flag(done_flag), .mask_bit(mask_bit)
    );

    spi_rm_engine #(.BYTE_W(BYTE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .cpol(cfg_cpol), .cpha(cfg_cpha), .tx_lsb(cfg_tx_lsb), .rx_lsb(cfg_rx_lsb),
        .late_sample(late_sample), .presc(cfg_presc), .miso(spi_miso),
        .busy(busy), .land(land), .rx_byte(rx_byte), .sck(spi_sck), .mosi(spi_mosi)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs_n[i] = !(cs_act && (cs_sel == CS_W'(i)));
    end

    assign irq = done_flag & mask_bit;

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk
    import spi_rm_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_valid,
    input logic               reg_we,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [NUM_CS-1:0]  cs_n,
    input logic               sck,
    input logic               irq,
    input logic               busy,
    input logic               cpol,
    input logic               done_flag,
    input logic [PRESC_W-1:0] presc
);
    logic clr_wr;
    assign clr_wr = reg_valid && reg_we && (reg_addr == A_CAUSE) && !reg_wdata[0];

    p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_sck_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && ($past(cpol) == cpol)) |-> (sck == cpol));

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !clr_wr) |=> done_flag);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

    p_presc_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        presc >= PRESC_W'(PRESC_FLOOR));

endmodule

bind spi_regmaster spi_regmaster_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cs_n(spi_cs_n), .sck(spi_sck),
    .irq(irq), .busy(busy), .cpol(cfg_cpol), .done_flag(done_flag), .presc(cfg_presc)
);

// File: tb/spi_regmaster_bench.sv
`timescale 1ns/1ps
module spi_regmaster_bench;
    import spi_rm_pkg::*;

    localparam int NUM_CS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_valid = 1'b0, reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_ready, irq, spi_sck, spi_mosi, spi_miso;
    logic [31:0]       reg_rdata;
    logic [NUM_CS-1:0] spi_cs_n;

    int tests = 0, fails = 0;
    bit finished = 0;

    spi_regmaster #(.NUM_CS(NUM_CS)) u_spi_regmaster (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    always #2.5 clk = ~clk;

    // remote device model
    logic       miso_i = 1'b0, miso_late = 1'b0;
    logic [7:0] sbyte = '0, srx = '0;
    int         sidx = 0;
    logic       tb_cpol = 1'b0, tb_cpha = 1'b0;
    bit         late_mode = 0;
    realtime    t_last = 0, t_gap = 0;
    int         cs1_rises = 0;

    always @(posedge clk) miso_late <= miso_i;
    assign spi_miso = late_mode ? miso_late : miso_i;
    always @(posedge spi_cs_n[1]) cs1_rises++;

    always @(spi_sck) begin
        if (!$isunknown(spi_cs_n) && spi_cs_n != {NUM_CS{1'b1}}) begin
            t_gap  = $realtime - t_last;
            t_last = $realtime;
            if (spi_sck !== tb_cpol) begin
                if (!tb_cpha) srx = {srx[6:0], spi_mosi};
                else if (sidx < 8) miso_i = sbyte[7-sidx];
            end else begin
                if (!tb_cpha) begin
                    sidx++;
                    if (sidx < 8) miso_i = sbyte[7-sidx];
                end else begin
                    srx = {srx[6:0], spi_mosi};
                    sidx++;
                end
            end
        end
    end

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(A_CTRL, v);
            if (!v[1]) break;
        end
    endtask

    task automatic setup(input logic pol, input logic pha, input logic rl, input logic tl,
                         input logic [7:0] ps, input logic [1:0] ts, input logic [1:0] sel);
        wr(A_CTRL, 32'(sel) << 4);
        tb_cpol = pol; tb_cpha = pha;
        wr(A_CFG, 32'(ps) | (32'(pol) << 8) | (32'(pha) << 9) | (32'(rl) << 10) | (32'(tl) << 11));
        wr(A_TIMING, 32'(ts));
        repeat (2) @(negedge clk);
        wr(A_CTRL, (32'(sel) << 4) | 32'd1);
    endtask

    task automatic launch(input logic [7:0] tx, input logic [7:0] sb);
        sbyte = sb; srx = '0; sidx = 0;
        if (!tb_cpha) miso_i = sb[7];
        repeat (2) @(negedge clk);
        wr(A_TXD, {24'hA5C3E1, tx});
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sb,
                        output logic [7:0] got_s, output logic [7:0] got_d);
        logic [31:0] v;
        launch(tx, sb);
        wait_idle();
        rd(A_RXD, v);
        got_d = v[7:0];
        got_s = srx;
        rd(A_CAUSE, v);
        check("R7 done set after byte", v, 32'd1);
        wr(A_CAUSE, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  gs, gd, tx, sb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n", 32'(spi_cs_n), 32'hF);
        check("R1 sck", 32'(spi_sck), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        rd(A_CFG, v);    check("R1 cfg", v, 32'h10);
        rd(A_TIMING, v); check("R1 timing", v, 32'd1);
        rd(A_CAUSE, v);  check("R1 cause", v, 32'd0);
        rd(A_CTRL, v);   check("R1 ctrl", v, 32'd0);
        rd(A_RXD, v);    check("R1 rxd", v, 32'd0);
        check("R2 ready", 32'(reg_ready), 32'd1);

        // R6 prescaler floor
        wr(A_CFG, 32'h005); rd(A_CFG, v); check("R6 clamp", v, 32'h010);
        wr(A_CFG, 32'h0FF); rd(A_CFG, v); check("R6 max kept", v, 32'h0FF);
        wr(A_CFG, 32'h010);

        // R9 select decode
        wr(A_CTRL, 32'h21); @(negedge clk); check("R9 sel2", 32'(spi_cs_n), 32'hB);
        wr(A_CTRL, 32'h20); @(negedge clk); check("R9 inactive", 32'(spi_cs_n), 32'hF);
        wr(A_CTRL, 32'h31); @(negedge clk); check("R9 sel3", 32'(spi_cs_n), 32'h7);

        // R4 idle level
        setup(1'b1, 1'b0, 1'b0, 1'b0, 8'h10, 2'd1, 2'd0);
        check("R4 idle high", 32'(spi_sck), 32'd1);
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 2'd1, 2'd0);
        check("R4 idle low", 32'(spi_sck), 32'd0);

        // R3 R4 R5 R11 sweep
        for (int m = 0; m < 4; m++)
          for (int tl = 0; tl < 2; tl++)
            for (int rl = 0; rl < 2; rl++)
              for (int p = 0; p < 2; p++)
                for (int t = 1; t < 3; t++) begin
                    setup(m[1], m[0], rl[0], tl[0], 8'h10 + 8'(p), 2'(t), 2'd1);
                    for (int k = 0; k < 3; k++) begin
                        tx = 8'(m*37 + tl*11 + rl*5 + k*91 + p*3 + t + 8'h1B);
                        sb = 8'(tx * 3 + 8'h5A + k);
                        xfer(tx, sb, gs, gd);
                        check("R3 R4 R5 mosi byte", 32'(gs), 32'(tl ? rev8(tx) : tx));
                        check("R4 R5 R11 rx byte", 32'(gd), 32'(rl ? rev8(sb) : sb));
                    end
                end

        // R6 half period: P=0x13 gives 4 clocks = 20 ns
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h13, 2'd1, 2'd1);
        xfer(8'h96, 8'h69, gs, gd);
        check("R6 half period ns", 32'($rtoi(t_gap + 0.01)), 32'd20);
        check("R6 slow byte", 32'(gd), 32'h69);

        // R9 select held across bytes
        setup(1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 2'd1, 2'd1);
        v = 32'(cs1_rises);
        xfer(8'h11, 8'h22, gs, gd);
        xfer(8'h33, 8'h44, gs, gd);
        check("R9 no release", 32'(cs1_rises), v);
        check("R9 still low", 32'(spi_cs_n[1]), 32'd0);

        // R7 R8 flag and interrupt
        launch(8'hC4, 8'h4C);
        wait_idle();
        rd(A_CAUSE, v); check("R7 set", v, 32'd1);
        check("R8 masked", 32'(irq), 32'd0);
        wr(A_CAUSE, 32'd1); rd(A_CAUSE, v); check("R7 write one kept", v, 32'd1);
        wr(A_MASK, 32'd1); @(negedge clk); check("R8 irq on", 32'(irq), 32'd1);
        wr(A_CAUSE, 32'd0); rd(A_CAUSE, v); check("R7 write zero clears", v, 32'd0);
        check("R8 irq off", 32'(irq), 32'd0);
        wr(A_MASK, 32'd0);

        // R10 write while busy
        launch(8'hA5, 8'h0F);
        wr(A_TXD, 32'h3C);
        wait_idle();
        check("R10 byte kept", 32'(srx), 32'hA5);
        rd(A_RXD, v); check("R10 rx", v, 32'h0F);
        repeat (6) @(negedge clk);
        rd(A_CTRL, v); check("R10 no second xfer", 32'(v[1]), 32'd0);
        wr(A_CAUSE, 32'd0);

        // R11 device answering one clock late
        late_mode = 1;
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 2'd2, 2'd1);
        xfer(8'h5D, 8'hB6, gs, gd);
        check("R11 delayed capture", 32'(gd), 32'hB6);
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 2'd1, 2'd1);
        xfer(8'h5D, 8'hB6, gs, gd);
        check("R11 edge capture", 32'(gd), 32'({1'b1, 7'(8'hB6 >> 1)}));
        late_mode = 0;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule